// File: doc/BRIEF.md
# I2C Transfer Byte Queue with Watermark Requests

This block is the byte store that sits between the register interface of an I2C master and its bus engine. One queue of `DEPTH` bytes serves both directions. In a write transfer the processor pushes bytes and the engine pops them. In a read transfer the engine pushes received bytes and the processor pops them. The `rx_mode` input selects the direction. Strobes that arrive on the side that does not own a given operation are ignored.

Two programmable watermarks raise level-sensitive requests, and each request has its own enable. The high watermark fires when the queue holds at least the set number of bytes, so a read handler can drain a block. The low watermark fires when the queue holds at most the set number, so a write handler can refill it. A one-cycle `flush` strobe empties the queue before each message. Registered `full` and `empty` flags give the fill state. The usual setting is a high level of 15 and a low level of 4.

Top module: `i2c_xfer_fifo`

## Requirements
- R1: After reset, and after any flush, `empty` is 1, `full` is 0, both IRQs are 0 (after reset) and both read-data ports show 0. `full` and `empty` are never 1 together.
- R2: Bytes leave the queue in the order they were accepted, with no loss or duplication while the queue is neither overflowing nor underflowing.
- R3: `full` is 1 exactly when `DEPTH` bytes are held. A push while full is dropped: nothing is overwritten and the occupancy does not change.
- R4: `empty` is 1 exactly when no byte is held. A pop while empty makes the read data 0 and leaves the occupancy unchanged.
- R5: With `rx_mode`=0, `host_push` writes and `eng_pop` reads, and `host_pop` and `eng_push` have no effect. With `rx_mode`=1, `eng_push` writes and `host_pop` reads, and `host_push` and `eng_pop` have no effect.
- R6: One cycle after the inputs, `af_irq` equals `af_irq_en` AND (occupancy >= `af_level`), where the occupancy is the value after that cycle's operations.
- R7: One cycle after the inputs, `ae_irq` equals `ae_irq_en` AND (occupancy <= `ae_level`), where the occupancy is the value after that cycle's operations.
- R8: `flush` discards all bytes and takes priority over any push or pop in the same cycle.
- R9: An accepted push and an accepted pop in the same cycle leave the occupancy unchanged. The popped byte is the oldest one.
- R10: The popped byte appears on `host_rdata` and `eng_rdata` in the cycle after the pop and holds until the next accepted pop, pop-while-empty or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | One-cycle strobe that empties the queue |
| rx_mode | input | 1 | 0: write transfer (host fills), 1: read transfer (engine fills) |
| af_level | input | LVL_W | High watermark level |
| ae_level | input | LVL_W | Low watermark level |
| af_irq_en | input | 1 | Enable for the high watermark request |
| ae_irq_en | input | 1 | Enable for the low watermark request |
| host_push | input | 1 | Processor-side push (write transfer) |
| host_wdata | input | DATA_W | Processor-side byte in |
| host_pop | input | 1 | Processor-side pop (read transfer) |
| host_rdata | output | DATA_W | Popped byte, processor view |
| eng_push | input | 1 | Engine-side push (read transfer) |
| eng_wdata | input | DATA_W | Engine-side byte in |
| eng_pop | input | 1 | Engine-side pop (write transfer) |
| eng_rdata | output | DATA_W | Popped byte, engine view |
| full | output | 1 | Queue holds DEPTH bytes |
| empty | output | 1 | Queue holds no byte |
| af_irq | output | 1 | High watermark request |
| ae_irq | output | 1 | Low watermark request |

## Verification
The in-module properties check the following on every cycle:
- the occupancy stays within bounds;
- `full` and `empty` never rise together;
- a push while full keeps the queue full, and a pop while empty yields zero data;
- a flush always leads to an empty queue;
- a cleared enable always silences its request.

The byte order, the direction swap, and the exact watermark thresholds for changing levels need a reference queue. The bench provides these through its model of the queue. That model runs through directed corners (fill past capacity, drain past empty, flush colliding with a push, push and pop together) and a long seeded random run that changes mode, levels and enables.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } xfer_dir_e;

  function automatic int unsigned ptr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/i2cq_store.sv
module i2cq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/i2cq_ctrl.sv
module i2cq_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] cnt_nxt,
  output logic          full,
  output logic          empty,
  output logic          zero_out
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          full_q, empty_q, zero_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && !full_q && !flush;
  assign pop_ok  = pop && !empty_q && !flush;

  always_comb begin
    if (flush)
      cnt_nxt = '0;
    else
      cnt_nxt = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push_ok) wptr_q <= bump(wptr_q);
      if (pop_ok)  rptr_q <= bump(rptr_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      zero_q  <= 1'b1;
    end else begin
      cnt_q   <= cnt_nxt;
      full_q  <= (cnt_nxt == CAP);
      empty_q <= (cnt_nxt == '0);
      if (flush)    zero_q <= 1'b1;
      else if (pop) zero_q <= empty_q;
    end
  end

  assign wr_en    = push_ok;
  assign wr_addr  = wptr_q;
  assign rd_en    = pop_ok;
  assign rd_addr  = rptr_q;
  assign full     = full_q;
  assign empty    = empty_q;
  assign zero_out = zero_q;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CAP);
  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (full_q && push && !pop && !flush) |=> full_q);
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (empty_q && pop && !push && !flush) |=> (empty_q && zero_q));
  p_flush_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty_q && !full_q));
  p_flag_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(full_q && empty_q));
endmodule

// File: rtl/i2cq_wmark.sv
module i2cq_wmark #(
  parameter int LVL_W = 4,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    cnt_nxt,
  input  logic [LVL_W-1:0] af_level,
  input  logic [LVL_W-1:0] ae_level,
  input  logic             af_en,
  input  logic             ae_en,
  output logic             af_irq,
  output logic             ae_irq
);
  logic [CW-1:0] af_ext, ae_ext;

  assign af_ext = CW'(af_level);
  assign ae_ext = CW'(ae_level);

  always_ff @(posedge clk) begin
    if (rst) begin
      af_irq <= 1'b0;
      ae_irq <= 1'b0;
    end else begin
      af_irq <= af_en && (cnt_nxt >= af_ext);
      ae_irq <= ae_en && (cnt_nxt <= ae_ext);
    end
  end

  p_af_masked_r6: assert property (@(posedge clk) disable iff (rst)
    !af_en |=> !af_irq);
  p_ae_masked_r7: assert property (@(posedge clk) disable iff (rst)
    !ae_en |=> !ae_irq);
endmodule

// File: rtl/i2c_xfer_fifo.sv
module i2c_xfer_fifo
  import i2cq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int LVL_W  = ptr_w(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              rx_mode,
  input  logic [LVL_W-1:0]  af_level,
  input  logic [LVL_W-1:0]  ae_level,
  input  logic              af_irq_en,
  input  logic              ae_irq_en,
  input  logic              host_push,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_pop,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              eng_push,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_pop,
  output logic [DATA_W-1:0] eng_rdata,
  output logic              full,
  output logic              empty,
  output logic              af_irq,
  output logic              ae_irq
);
  localparam int AW = ptr_w(DEPTH);
  localparam int CW = AW + 1;

  xfer_dir_e         dir;
  logic              push, pop;
  logic [DATA_W-1:0] wdata, rd_q;
  logic              wr_en, rd_en, zero_q;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [CW-1:0]     cnt_nxt;

  assign dir   = xfer_dir_e'(rx_mode);
  assign push  = (dir == DIR_RX) ? eng_push  : host_push;
  assign pop   = (dir == DIR_RX) ? host_pop  : eng_pop;
  assign wdata = (dir == DIR_RX) ? eng_wdata : host_wdata;

  i2cq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .pop(pop),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .cnt_nxt(cnt_nxt), .full(full), .empty(empty), .zero_out(zero_q)
  );

  i2cq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_q)
  );

  i2cq_wmark #(.LVL_W(LVL_W), .CW(CW)) u_wmark (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt),
    .af_level(af_level), .ae_level(ae_level),
    .af_en(af_irq_en), .ae_en(ae_irq_en),
    .af_irq(af_irq), .ae_irq(ae_irq)
  );

  assign host_rdata = zero_q ? '0 : rd_q;
  assign eng_rdata  = host_rdata;

  p_dir_tx_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!rx_mode && !flush && !host_push && !eng_pop && empty) |=> empty);
  p_dir_rx_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_mode && !flush && !eng_push && !host_pop && empty) |=> empty);
endmodule

// File: tb/i2c_xfer_fifo_tb_top.sv
`timescale 1ns/1ps
module i2c_xfer_fifo_tb_top;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst, flush, rx_mode, af_irq_en, ae_irq_en;
  logic [3:0] af_level, ae_level;
  logic       host_push, host_pop, eng_push, eng_pop;
  logic [7:0] host_wdata, eng_wdata, host_rdata, eng_rdata;
  logic       full, empty, af_irq, ae_irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] mq[$];
  logic [7:0] exp_rd = 8'h00;

  always #2.5 clk = ~clk;

  i2c_xfer_fifo dut_i (
    .clk(clk), .rst(rst), .flush(flush), .rx_mode(rx_mode),
    .af_level(af_level), .ae_level(ae_level),
    .af_irq_en(af_irq_en), .ae_irq_en(ae_irq_en),
    .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop),
    .host_rdata(host_rdata), .eng_push(eng_push), .eng_wdata(eng_wdata),
    .eng_pop(eng_pop), .eng_rdata(eng_rdata), .full(full), .empty(empty),
    .af_irq(af_irq), .ae_irq(ae_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_af();
    return !rst && af_irq_en && (mq.size() >= int'(af_level));
  endfunction
  function automatic bit exp_ae();
    return !rst && ae_irq_en && (mq.size() <= int'(ae_level));
  endfunction

  task automatic idle();
    flush = 0; host_push = 0; host_pop = 0; eng_push = 0; eng_pop = 0;
  endtask

  task automatic step();
    bit pe, po, was_e, was_f, e_af, e_ae;
    logic [7:0] d;
    @(posedge clk);
    if (rst || flush) begin
      mq.delete();
      exp_rd = 8'h00;
    end else begin
      pe = rx_mode ? eng_push : host_push;
      po = rx_mode ? host_pop : eng_pop;
      d  = rx_mode ? eng_wdata : host_wdata;
      was_e = (mq.size() == 0);
      was_f = (mq.size() == DEPTH);
      if (po) exp_rd = was_e ? 8'h00 : mq.pop_front();
      if (pe && !was_f) mq.push_back(d);
    end
    e_af = exp_af();
    e_ae = exp_ae();
    #1;
    chk(full === (mq.size() == DEPTH), "R3 full", full, mq.size() == DEPTH);
    chk(empty === (mq.size() == 0), "R4 empty", empty, mq.size() == 0);
    chk(af_irq === e_af, "R6 af_irq", af_irq, e_af);
    chk(ae_irq === e_ae, "R7 ae_irq", ae_irq, e_ae);
    chk(host_rdata === exp_rd, "R2/R10 host_rdata", host_rdata, exp_rd);
    chk(eng_rdata === exp_rd, "R2/R10 eng_rdata", eng_rdata, exp_rd);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle();
    rst = 1; rx_mode = 0; af_level = 4'd15; ae_level = 4'd4;
    af_irq_en = 0; ae_irq_en = 0; host_wdata = 0; eng_wdata = 0;
    step(); step();
    rst = 0; step();
    // R1: reset state
    chk(empty && !full && !af_irq && !ae_irq && host_rdata == 0, "R1 reset state",
        {empty, full, af_irq, ae_irq}, 4'b1000);

    // R3: fill a write queue past capacity
    af_irq_en = 1; ae_irq_en = 1;
    for (int i = 0; i < DEPTH + 1; i++) begin
      host_push = 1; host_wdata = 8'h30 + 8'(i); step();
    end
    idle();
    chk(full === 1'b1, "R3 full after overfill", full, 1);
    chk(af_irq === 1'b1, "R6 af at level 15", af_irq, 1);
    // R2: drain in order, then R4: one more pop returns zero
    for (int i = 0; i < DEPTH; i++) begin
      eng_pop = 1; step();
      chk(eng_rdata === 8'h30 + 8'(i), "R2 order", eng_rdata, 8'h30 + 8'(i));
    end
    eng_pop = 1; step(); idle();
    chk(eng_rdata === 8'h00 && empty, "R4 pop empty gives zero", eng_rdata, 0);
    step();
    chk(ae_irq === 1'b1, "R7 ae when empty", ae_irq, 1);

    // R5: wrong-side strobes in write mode are ignored
    eng_push = 1; eng_wdata = 8'hAA; step(); idle();
    chk(empty === 1'b1, "R5 eng_push ignored in tx", empty, 1);
    host_push = 1; host_wdata = 8'h5C; step(); idle();
    host_pop = 1; step(); idle();
    chk(!empty && host_rdata == 8'h00, "R5 host_pop ignored in tx", host_rdata, 0);
    // R5: read mode, engine fills and host drains
    rx_mode = 1; flush = 1; step(); idle();
    chk(empty === 1'b1, "R8 flush empties", empty, 1);
    eng_push = 1; eng_wdata = 8'hC3; host_push = 1; host_wdata = 8'h11; step(); idle();
    host_pop = 1; step(); idle();
    chk(host_rdata === 8'hC3 && empty, "R5 rx path", host_rdata, 8'hC3);
    step();
    chk(host_rdata === 8'hC3, "R10 rdata holds", host_rdata, 8'hC3);

    // R6/R7 threshold edges and R9 simultaneous push and pop
    af_level = 4'd5; ae_level = 4'd4;
    for (int i = 0; i < 4; i++) begin
      eng_push = 1; eng_wdata = 8'h70 + 8'(i); step();
    end
    idle(); step();
    chk(!af_irq && ae_irq, "R7 ae at level 4", {af_irq, ae_irq}, 2'b01);
    eng_push = 1; eng_wdata = 8'h74; step(); idle(); step();
    chk(af_irq && !ae_irq, "R6 af at level 5", {af_irq, ae_irq}, 2'b10);
    eng_push = 1; eng_wdata = 8'h75; host_pop = 1; step(); idle(); step();
    chk(af_irq && !ae_irq && host_rdata == 8'h70, "R9 count kept, oldest out",
        host_rdata, 8'h70);
    // R8: flush beats a same-cycle push
    flush = 1; eng_push = 1; step(); idle();
    chk(empty && !full, "R8 flush wins over push", empty, 1);

    // Random run
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 200 == 0) rx_mode = ~rx_mode;
      if ($urandom % 50 == 0) begin
        af_level = 4'($urandom); ae_level = 4'($urandom);
        af_irq_en = 1'($urandom); ae_irq_en = 1'($urandom);
      end
      flush = ($urandom % 80 == 0);
      host_push = 1'($urandom); eng_push = 1'($urandom);
      host_pop = ($urandom % 3 == 0); eng_pop = ($urandom % 3 == 0);
      host_wdata = 8'($urandom); eng_wdata = 8'($urandom);
      step();
    end
    idle(); step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule